// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with status register

This block is the execute stage of a small eight-bit microcontroller datapath. Each cycle it takes two byte operands, a five-bit operation code, a bit index and a six-bit constant. It returns a byte result and a sixteen-bit register-pair result combinationally, in the same cycle. It also keeps an eight-bit status register, which it updates on the next rising clock edge. The carry and bit-copy flags held in that register feed back into rotates, add-with-carry and bit load.

The surrounding core does the instruction decode and owns the register file. It places the destination value on `a_i` and the source value on `b_i`. For a word operation it places the low byte of the pair on `a_i` and the high byte on `b_i`. It writes back `result_o` or `word_o` as the instruction requires. The status register can be loaded as a whole or one bit at a time, and it is always visible on `flags_o`.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i`: 0 no-op, 1 add, 2 add with carry, 3 subtract, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 two's complement, 9 increment, 10 decrement, 11 shift left, 12 logical shift right, 13 arithmetic shift right, 14 rotate left through carry, 15 rotate right through carry, 16 nibble swap, 17 bit store, 18 bit load, 19 status bit set, 20 status bit clear, 21 word add, 22 status write. Codes 23 to 31 act as a no-op. `result_o` reflects the current inputs in the same cycle. `flags_o` changes only at the rising edge that follows.
- R2: Status bits, bit 7 down to bit 0, are: interrupt enable, bit-copy T, half carry H, sign S, overflow V, negative N, zero Z and carry C. Reset (`rst_n` low) clears all eight bits. Status write copies `a_i` into all eight bits and outputs `a_i`.
- R3: Add outputs a+b and add with carry outputs a+b+C. In both, C is the carry out of bit 7, H is the carry out of bit 3, V is the signed overflow, N is result bit 7, and Z is set for a zero result.
- R4: Subtract outputs a-b and two's complement outputs 0-a. In both, C is the borrow out of bit 7, H is the borrow into bit 4, V is the signed overflow, and N and Z follow the result.
- R5: Increment and decrement set V only when the operand is 0x7F or 0x80 respectively. They leave C and H unchanged, and N and Z follow the result.
- R6: AND, OR and XOR clear V and leave C and H unchanged. One's complement outputs ~a, sets C and clears V. In all four, N and Z follow the result.
- R7: Shift left inserts 0, and rotate left inserts the old C. Both move bit 7 into C and copy operand bit 3 into H. Logical shift right inserts 0, arithmetic shift right keeps bit 7, and rotate right inserts the old C at bit 7. All three move bit 0 into C and leave H unchanged. Every shift and rotate sets V to N xor C.
- R8: Nibble swap outputs {a[3:0], a[7:4]}. Swap and no-op leave all eight status bits unchanged.
- R9: Bit store copies `a_i[sel_i]` into T and outputs `a_i`. Bit load outputs `a_i` with bit `sel_i` replaced by T and leaves the status unchanged.
- R10: Status set and status clear force status bit `sel_i` to 1 or 0 respectively. The other seven bits stay unchanged.
- R11: Word add outputs `word_o` = {b_i, a_i} + `imm_i` (0 to 63) and `result_o` = its low byte. C is the carry out of bit 15, and V is set when bit 15 rises from 0 to 1. N is bit 15, and Z is set when all sixteen bits are zero. H is unchanged.
- R12: For every arithmetic, logic, shift and word operation, S equals N xor V. The interrupt-enable bit changes only through status write, status set or status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the status register |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Destination operand, or low byte of the register pair |
| b_i | input | 8 | Source operand, or high byte of the register pair |
| sel_i | input | 3 | Bit index for bit store, bit load, status set and status clear |
| imm_i | input | 6 | Constant added by the word add |
| result_o | output | 8 | Byte result |
| word_o | output | 16 | Register-pair sum {b_i, a_i} + imm_i |
| flags_o | output | 8 | Current status register |

## Verification
A wrong status bit stays in the register until an operation rewrites it. Carry and T feed straight back into the next rotate, add with carry or bit load, so a fault in either shows up in `result_o` one cycle later. A fault in any other bit shows on `flags_o` right after the edge that stores it. Each vector therefore preloads a known status value, applies one operation, checks `result_o` within that cycle and checks all eight flags after the next edge. The vectors include operand values that lie on the overflow, half-carry and zero boundaries.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW   = 8;
    localparam int WW   = 2 * DW;
    localparam int HB   = DW / 2;
    localparam int SELW = $clog2(DW);
    localparam int IMMW = 6;
    localparam int OPW  = 5;

    // status bit positions
    localparam int FI = 7;
    localparam int FT = 6;
    localparam int FH = 5;
    localparam int FS = 4;
    localparam int FV = 3;
    localparam int FN = 2;
    localparam int FZ = 1;
    localparam int FC = 0;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_ADC  = 5'd2,  OP_SUB  = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
        OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL  = 5'd11,
        OP_LSR  = 5'd12, OP_ASR  = 5'd13, OP_ROL  = 5'd14, OP_ROR  = 5'd15,
        OP_SWAP = 5'd16, OP_BST  = 5'd17, OP_BLD  = 5'd18, OP_BSET = 5'd19,
        OP_BCLR = 5'd20, OP_ADIW = 5'd21, OP_SRW  = 5'd22
    } op_e;

    typedef struct packed {
        logic [DW-1:0] sreg;
    } state_t;

    function automatic logic is_arith(op_e op);
        return op inside {OP_ADD, OP_ADC, OP_SUB, OP_NEG, OP_INC, OP_DEC, OP_ADIW};
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  op_e               op,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic [IMMW-1:0]   imm,
    input  logic [DW-1:0]     f_in,
    output logic [DW-1:0]     res,
    output logic [WW-1:0]     word,
    output logic [DW-1:0]     f_out
);

    localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] MAXP = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINN = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0]   sum;
    logic [HB:0]   lo;
    logic [WW:0]   wsum;
    logic [DW-1:0] x;
    logic [DW-1:0] y;
    logic          cin;

    always_comb begin
        f_out = f_in;
        wsum  = {1'b0, b, a} + {{(WW+1-IMMW){1'b0}}, imm};
        word  = wsum[WW-1:0];
        res   = a;
        sum   = '0;
        lo    = '0;
        x     = a;
        y     = b;
        cin   = (op == OP_ADC) ? f_in[FC] : 1'b0;

        unique case (op)
            OP_ADD, OP_ADC: begin
                sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
                lo  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
                res = sum[DW-1:0];
                f_out[FC] = sum[DW];
                f_out[FH] = lo[HB];
                f_out[FV] = (a[DW-1] == b[DW-1]) && (res[DW-1] != a[DW-1]);
            end
            OP_SUB, OP_NEG: begin
                x   = (op == OP_NEG) ? '0 : a;
                y   = (op == OP_NEG) ? a  : b;
                sum = {1'b0, x} - {1'b0, y};
                lo  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]};
                res = sum[DW-1:0];
                f_out[FC] = sum[DW];
                f_out[FH] = lo[HB];
                f_out[FV] = (x[DW-1] != y[DW-1]) && (res[DW-1] != x[DW-1]);
            end
            OP_INC: begin
                res = a + ONE;
                f_out[FV] = (a == MAXP);
            end
            OP_DEC: begin
                res = a - ONE;
                f_out[FV] = (a == MINN);
            end
            default: ;
        endcase

        if (op == OP_ADIW) begin
            res       = wsum[DW-1:0];
            f_out[FC] = wsum[WW];
            f_out[FV] = !b[DW-1] && wsum[WW-1];
            f_out[FN] = wsum[WW-1];
            f_out[FZ] = (wsum[WW-1:0] == '0);
        end else begin
            f_out[FN] = res[DW-1];
            f_out[FZ] = (res == '0);
        end
        f_out[FS] = f_out[FN] ^ f_out[FV];
    end

endmodule

// File: rtl/alu8_bits.sv
module alu8_bits
    import alu8_pkg::*;
(
    input  op_e               op,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic [SELW-1:0]   sel,
    input  logic [DW-1:0]     f_in,
    output logic [DW-1:0]     res,
    output logic [DW-1:0]     f_out
);

    logic upd;
    logic shv;

    always_comb begin
        f_out = f_in;
        res   = a;
        upd   = 1'b0;
        shv   = 1'b0;

        unique case (op)
            OP_AND:  begin res = a & b; f_out[FV] = 1'b0; upd = 1'b1; end
            OP_OR:   begin res = a | b; f_out[FV] = 1'b0; upd = 1'b1; end
            OP_XOR:  begin res = a ^ b; f_out[FV] = 1'b0; upd = 1'b1; end
            OP_COM:  begin
                res = ~a;
                f_out[FC] = 1'b1;
                f_out[FV] = 1'b0;
                upd = 1'b1;
            end
            OP_LSL, OP_ROL: begin
                res = {a[DW-2:0], (op == OP_ROL) ? f_in[FC] : 1'b0};
                f_out[FC] = a[DW-1];
                f_out[FH] = a[HB-1];
                shv = 1'b1;
            end
            OP_LSR:  begin res = {1'b0, a[DW-1:1]};      f_out[FC] = a[0]; shv = 1'b1; end
            OP_ASR:  begin res = {a[DW-1], a[DW-1:1]};   f_out[FC] = a[0]; shv = 1'b1; end
            OP_ROR:  begin res = {f_in[FC], a[DW-1:1]};  f_out[FC] = a[0]; shv = 1'b1; end
            OP_SWAP: res = {a[HB-1:0], a[DW-1:HB]};
            OP_BST:  f_out[FT] = a[sel];
            OP_BLD:  res[sel] = f_in[FT];
            OP_BSET: f_out[sel] = 1'b1;
            OP_BCLR: f_out[sel] = 1'b0;
            OP_SRW:  f_out = a;
            default: ;
        endcase

        if (shv) begin
            f_out[FN] = res[DW-1];
            f_out[FV] = res[DW-1] ^ f_out[FC];
            upd = 1'b1;
        end
        if (upd) begin
            f_out[FN] = res[DW-1];
            f_out[FZ] = (res == '0);
            f_out[FS] = f_out[FN] ^ f_out[FV];
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPW-1:0]    op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic [SELW-1:0]   sel_i,
    input  logic [IMMW-1:0]   imm_i,
    output logic [DW-1:0]     result_o,
    output logic [WW-1:0]     word_o,
    output logic [DW-1:0]     flags_o
);

    op_e           op;
    state_t        st_d;
    state_t        st_q;
    logic [DW-1:0] ar_res;
    logic [DW-1:0] ar_flg;
    logic [DW-1:0] bt_res;
    logic [DW-1:0] bt_flg;
    logic [WW-1:0] ar_word;

    assign op = op_e'(op_i);

    alu8_arith u_arith (
        .op    (op),
        .a     (a_i),
        .b     (b_i),
        .imm   (imm_i),
        .f_in  (st_q.sreg),
        .res   (ar_res),
        .word  (ar_word),
        .f_out (ar_flg)
    );

    alu8_bits u_bits (
        .op    (op),
        .a     (a_i),
        .b     (b_i),
        .sel   (sel_i),
        .f_in  (st_q.sreg),
        .res   (bt_res),
        .f_out (bt_flg)
    );

    always_comb begin
        st_d = st_q;
        if (is_arith(op)) begin
            st_d.sreg = ar_flg;
            result_o  = ar_res;
        end else begin
            st_d.sreg = bt_flg;
            result_o  = bt_res;
        end
        word_o  = ar_word;
        flags_o = st_q.sreg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [OPW-1:0]  op_i,
    input logic [DW-1:0]   a_i,
    input logic [DW-1:0]   result_o,
    input logic [DW-1:0]   flags_o
);

    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SRW) |=> (flags_o == $past(a_i)));  // R2

    AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {OP_ADD, OP_ADC}) |=> (flags_o[FZ] == ($past(result_o) == '0)));  // R3

    AST_COM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COM) |=> flags_o[FC]);  // R6

    AST_SWAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {OP_SWAP, OP_NOP}) |=> $stable(flags_o));  // R8

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {OP_ADD, OP_ADC, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_COM, OP_NEG,
                      OP_INC, OP_DEC, OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR, OP_ADIW})
        |=> (flags_o[FS] == (flags_o[FN] ^ flags_o[FV])));  // R12

    AST_IE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_i inside {OP_SRW, OP_BSET, OP_BCLR}) |=> (flags_o[FI] == $past(flags_o[FI])));  // R12

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .result_o (result_o),
    .flags_o  (flags_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
    import alu8_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic [2:0]  sel_i = '0;
    logic [5:0]  imm_i = '0;
    logic [7:0]  result_o;
    logic [15:0] word_o;
    logic [7:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .sel_i(sel_i), .imm_i(imm_i), .result_o(result_o), .word_o(word_o), .flags_o(flags_o)
    );

    // {op, status before, a, b, sel, imm, expected result, expected status}
    localparam int NV = 35;
    localparam logic [53:0] VEC [0:NV-1] = '{
        {OP_ADD,  8'h00, 8'h0F, 8'h01, 3'd0, 6'd0,  8'h10, 8'h20},
        {OP_ADD,  8'h00, 8'h7F, 8'h01, 3'd0, 6'd0,  8'h80, 8'h2C},
        {OP_ADD,  8'h00, 8'hFF, 8'h01, 3'd0, 6'd0,  8'h00, 8'h23},
        {OP_ADC,  8'h01, 8'h10, 8'h20, 3'd0, 6'd0,  8'h31, 8'h00},
        {OP_ADC,  8'h01, 8'hFF, 8'h00, 3'd0, 6'd0,  8'h00, 8'h23},
        {OP_SUB,  8'h00, 8'h10, 8'h01, 3'd0, 6'd0,  8'h0F, 8'h20},
        {OP_SUB,  8'h00, 8'h01, 8'h02, 3'd0, 6'd0,  8'hFF, 8'h35},
        {OP_SUB,  8'h00, 8'h80, 8'h01, 3'd0, 6'd0,  8'h7F, 8'h38},
        {OP_AND,  8'hFF, 8'hF0, 8'h3C, 3'd0, 6'd0,  8'h30, 8'hE1},
        {OP_OR,   8'h00, 8'h00, 8'h00, 3'd0, 6'd0,  8'h00, 8'h02},
        {OP_XOR,  8'h08, 8'hAA, 8'h55, 3'd0, 6'd0,  8'hFF, 8'h14},
        {OP_COM,  8'h00, 8'h0F, 8'h00, 3'd0, 6'd0,  8'hF0, 8'h15},
        {OP_NEG,  8'h00, 8'h01, 8'h00, 3'd0, 6'd0,  8'hFF, 8'h35},
        {OP_NEG,  8'h00, 8'h80, 8'h00, 3'd0, 6'd0,  8'h80, 8'h0D},
        {OP_NEG,  8'h00, 8'h00, 8'h00, 3'd0, 6'd0,  8'h00, 8'h02},
        {OP_INC,  8'h01, 8'h7F, 8'h00, 3'd0, 6'd0,  8'h80, 8'h0D},
        {OP_INC,  8'h00, 8'hFF, 8'h00, 3'd0, 6'd0,  8'h00, 8'h02},
        {OP_DEC,  8'h00, 8'h80, 8'h00, 3'd0, 6'd0,  8'h7F, 8'h18},
        {OP_LSL,  8'h00, 8'h88, 8'h00, 3'd0, 6'd0,  8'h10, 8'h39},
        {OP_LSR,  8'h00, 8'h01, 8'h00, 3'd0, 6'd0,  8'h00, 8'h1B},
        {OP_ASR,  8'h00, 8'h81, 8'h00, 3'd0, 6'd0,  8'hC0, 8'h15},
        {OP_ROL,  8'h01, 8'h80, 8'h00, 3'd0, 6'd0,  8'h01, 8'h19},
        {OP_ROR,  8'h01, 8'h02, 8'h00, 3'd0, 6'd0,  8'h81, 8'h0C},
        {OP_SWAP, 8'h5A, 8'h3C, 8'h00, 3'd0, 6'd0,  8'hC3, 8'h5A},
        {OP_BST,  8'h00, 8'h08, 8'h00, 3'd3, 6'd0,  8'h08, 8'h40},
        {OP_BST,  8'hFF, 8'hF7, 8'h00, 3'd3, 6'd0,  8'hF7, 8'hBF},
        {OP_BLD,  8'h40, 8'h00, 8'h00, 3'd6, 6'd0,  8'h40, 8'h40},
        {OP_BLD,  8'h00, 8'hFF, 8'h00, 3'd0, 6'd0,  8'hFE, 8'h00},
        {OP_BSET, 8'h00, 8'h12, 8'h00, 3'd7, 6'd0,  8'h12, 8'h80},
        {OP_BCLR, 8'hFF, 8'h12, 8'h00, 3'd1, 6'd0,  8'h12, 8'hFD},
        {OP_ADIW, 8'h00, 8'hFF, 8'h00, 3'd0, 6'd1,  8'h00, 8'h00},
        {OP_ADIW, 8'h00, 8'hFF, 8'h7F, 3'd0, 6'd1,  8'h00, 8'h0C},
        {OP_ADIW, 8'h00, 8'hC2, 8'hFF, 3'd0, 6'd62, 8'h00, 8'h03},
        {OP_NOP,  8'hA5, 8'h55, 8'h00, 3'd0, 6'd0,  8'h55, 8'hA5},
        {OP_ADD,  8'hC0, 8'h01, 8'h01, 3'd0, 6'd0,  8'h02, 8'hC0}
    };

    function automatic string req_of(logic [4:0] op);
        case (op)
            OP_ADD, OP_ADC:                         return "R3";
            OP_SUB, OP_NEG:                         return "R4";
            OP_INC, OP_DEC:                         return "R5";
            OP_AND, OP_OR, OP_XOR, OP_COM:          return "R6";
            OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: return "R7";
            OP_SWAP, OP_NOP:                        return "R8";
            OP_BST, OP_BLD:                         return "R9";
            OP_BSET, OP_BCLR:                       return "R10";
            OP_ADIW:                                return "R11";
            default:                                return "R1";
        endcase
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_status(logic [7:0] v);
        @(negedge clk);
        op_i = OP_SRW; a_i = v;
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R2", "status at reset", {8'h00, flags_o}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            automatic logic [53:0] v = VEC[i];
            automatic string rq = req_of(v[53:49]);
            load_status(v[48:41]);
            @(negedge clk);
            op_i = v[53:49]; a_i = v[40:33]; b_i = v[32:25]; sel_i = v[24:22]; imm_i = v[21:16];
            #1;
            check(rq, $sformatf("result row %0d", i), {8'h00, result_o}, {8'h00, v[15:8]});
            if (v[53:49] == OP_ADIW)
                check("R11", $sformatf("word row %0d", i), word_o, {v[32:25], v[40:33]} + {10'd0, v[21:16]});
            @(posedge clk);
            #1;
            check(rq, $sformatf("status row %0d", i), {8'h00, flags_o}, {8'h00, v[7:0]});
        end

        // R2: full status write and readback
        load_status(8'hFF);
        #1;
        check("R2", "status write all ones", {8'h00, flags_o}, 16'h00FF);

        // R1: flags update only at the edge, result is immediate
        @(negedge clk);
        op_i = OP_BCLR; sel_i = 3'd7; a_i = 8'h3E;
        #1;
        check("R1", "status before edge", {8'h00, flags_o}, 16'h00FF);
        check("R1", "same-cycle result", {8'h00, result_o}, 16'h003E);
        @(posedge clk);
        #1;
        check("R10", "clear interrupt enable", {8'h00, flags_o}, 16'h007F);

        // R1: undefined code behaves as no-op
        @(negedge clk);
        op_i = 5'd27; a_i = 8'h9C;
        @(posedge clk);
        #1;
        check("R1", "undefined code status", {8'h00, flags_o}, 16'h007F);
        check("R1", "undefined code result", {8'h00, result_o}, 16'h009C);

        // R12: two back-to-back ops chain carry, I unaffected
        load_status(8'h81);
        @(negedge clk);
        op_i = OP_ROL; a_i = 8'h00;
        #1;
        check("R7", "rotate uses held carry", {8'h00, result_o}, 16'h0001);
        @(posedge clk);
        #1;
        check("R12", "interrupt enable kept", {15'd0, flags_o[7]}, 16'h0001);

        // R2: reset in mid-run clears the status
        load_status(8'h5A);
        @(negedge clk);
        rst_n = 1'b0; op_i = OP_NOP;
        @(posedge clk);
        #1;
        check("R2", "reset clears status", {8'h00, flags_o}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule